// File: doc/BRIEF.md
# Burst and Trigger Sequencer

This block decides, clock by clock, whether a pulse is to be issued. It takes a mode and a trigger selection. From them it produces a per-clock pulse-enable for the output stage and a trigger-out strobe that marks where each pulse or frame begins. It is placed in the generator clock domain. The external input reaches it already synchronised, and the software trigger arrives as a one-clock strobe.

In burst mode, each launch opens a frame of a set number of clocks, and the enable is high only for the first few clocks of that frame. In pattern mode the enable gates every clock of the frame. In single-pulse mode a launch gives exactly one clock of enable. In follow mode the sequencer steps aside: the enable tracks the external input and the trigger strobe stays quiet. The frame settings are checked as they arrive. A bad combination raises an error flag, and the last good settings stay in force.

Top module: `burst_seq`

## Requirements
- R1: In burst mode (mode code 1) a launched frame lasts `per` clocks, pulse_en_o is high on its first `cnt` clocks and low on the rest, and trig_out_o is high only on its first clock.
- R2: In pattern mode (mode code 2) pulse_en_o is high on every clock of a `per`-clock frame, with trig_out_o high on the frame's first clock.
- R3: In single-pulse mode (mode code 0) each launch produces one clock of pulse_en_o together with trig_out_o in that same clock.
- R4: With trigger code 0 (internal), frames repeat back to back with no idle clock, so single-pulse mode enables every clock.
- R5: With trigger code 1 (edge), a low-to-high change on ext_i launches exactly one frame. A rising edge that arrives while a frame is running is dropped and is not queued.
- R6: With trigger code 2 (level), frames repeat while ext_i is high. When ext_i goes low, the frame already running completes before output stops.
- R7: With trigger code 3 (software), each sw_trig_i strobe received while idle launches one frame. Strobes received during a frame are ignored.
- R8: In follow mode (mode code 3), pulse_en_o equals ext_i delayed by one clock and trig_out_o stays low.
- R9: A setting is valid when 2 <= cnt <= 1048576, 8 <= per <= 1048576 and per >= cnt. When the setting is invalid, cfg_err_o is high on the next clock and the previous valid setting stays in use.
- R10: After reset, pulse_en_o, trig_out_o and cfg_err_o are low. The held setting is cnt=2, per=8. Every output change appears one clock after the edge that samples its cause.

Direct port mapping: R1 uses ports `burst_cnt_i` (for `cnt`) and `burst_per_i` (for `per`); R2 uses `burst_per_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 single pulse, 1 burst, 2 pattern, 3 follow |
| trig_i | input | 2 | 0 internal, 1 edge, 2 level, 3 software |
| burst_cnt_i | input | 21 | Enabled clocks per burst frame |
| burst_per_i | input | 21 | Frame length in clocks |
| ext_i | input | 1 | Synchronised external input |
| sw_trig_i | input | 1 | One-clock software trigger strobe |
| pulse_en_o | output | 1 | Per-clock pulse enable |
| trig_out_o | output | 1 | Trigger-out strobe |
| cfg_err_o | output | 1 | Rejected-setting flag |

## Verification
The frame position counter and the running flag are the state that matters. A position that slips by even one count changes how many enabled clocks fall between two trigger-out strobes. That is visible within a single frame of at most `per` clocks, so the bench counts enables and strobes over whole frames. A setting that was not held correctly, or a launch that was queued when it should have been dropped, shows up as an extra or missing frame within a couple of periods.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        MD_PULSE   = 2'd0,
        MD_BURST   = 2'd1,
        MD_PATTERN = 2'd2,
        MD_FOLLOW  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        TG_INT   = 2'd0,
        TG_EDGE  = 2'd1,
        TG_LEVEL = 2'd2,
        TG_SOFT  = 2'd3
    } trig_e;

    // launch requests handed from the trigger logic to the frame counter
    typedef struct packed {
        logic from_idle;
        logic at_end;
    } launch_t;

    function automatic logic cfg_ok(input logic [31:0] c, input logic [31:0] p,
                                    input logic [31:0] min_c, input logic [31:0] min_p,
                                    input logic [31:0] max_v);
        return (c >= min_c) && (c <= max_v) && (p >= min_p) && (p <= max_v) && (p >= c);
    endfunction

endpackage

// File: rtl/bseq_cfg_guard.sv
module bseq_cfg_guard
    import burst_seq_pkg::*;
#(
    parameter int CNT_W   = 21,
    parameter int MIN_CNT = 2,
    parameter int MIN_PER = 8,
    parameter int MAX_LEN = 1048576
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic             err_o
);
    logic good;

    always_comb begin
        good = cfg_ok(32'(cnt_i), 32'(per_i), 32'(MIN_CNT), 32'(MIN_PER), 32'(MAX_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= CNT_W'(MIN_CNT);
            per_o <= CNT_W'(MIN_PER);
            err_o <= 1'b0;
        end else begin
            err_o <= !good;
            if (good) begin
                cnt_o <= cnt_i;
                per_o <= per_i;
            end
        end
    end
endmodule

// File: rtl/bseq_trig.sv
module bseq_trig
    import burst_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  trig_e   trig,
    input  logic    ext_i,
    input  logic    sw_i,
    output launch_t req_o,
    output logic    ext_q_o
);
    logic ext_q;
    logic rise;

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= ext_i;
    end

    assign rise    = ext_i & ~ext_q;
    assign ext_q_o = ext_q;

    always_comb begin
        req_o = '0;
        unique case (trig)
            TG_INT: begin
                req_o.from_idle = 1'b1;
                req_o.at_end    = 1'b1;
            end
            TG_EDGE: begin
                req_o.from_idle = rise;
                req_o.at_end    = 1'b0;
            end
            TG_LEVEL: begin
                req_o.from_idle = ext_i;
                req_o.at_end    = ext_i;
            end
            TG_SOFT: begin
                req_o.from_idle = sw_i;
                req_o.at_end    = 1'b0;
            end
            default: req_o = '0;
        endcase
    end
endmodule

// File: rtl/bseq_frame.sv
module bseq_frame
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  launch_t          req,
    input  logic [CNT_W-1:0] len_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic             busy_o,
    output logic             first_o,
    output logic             last_o,
    output logic             in_hi_o
);
    logic             busy;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] len_r;
    logic [CNT_W-1:0] hi_r;
    logic             last;
    logic             go;

    assign last = busy && (pos == len_r - 1'b1);
    assign go   = (!busy && req.from_idle) || (last && req.at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            pos   <= '0;
            len_r <= CNT_W'(1);
            hi_r  <= CNT_W'(1);
        end else if (hold) begin
            busy <= 1'b0;
            pos  <= '0;
        end else if (go) begin
            busy  <= 1'b1;
            pos   <= '0;
            len_r <= len_i;
            hi_r  <= hi_i;
        end else if (last) begin
            busy <= 1'b0;
            pos  <= '0;
        end else if (busy) begin
            pos <= pos + 1'b1;
        end
    end

    assign busy_o  = busy;
    assign first_o = busy && (pos == '0);
    assign last_o  = last;
    assign in_hi_o = busy && (pos < hi_r);
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int CNT_W   = 21,
    parameter int MIN_CNT = 2,
    parameter int MIN_PER = 8,
    parameter int MAX_LEN = 1048576
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       trig_i,
    input  logic [CNT_W-1:0] burst_cnt_i,
    input  logic [CNT_W-1:0] burst_per_i,
    input  logic             ext_i,
    input  logic             sw_trig_i,
    output logic             pulse_en_o,
    output logic             trig_out_o,
    output logic             cfg_err_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    mode_e            mode;
    trig_e            trig;
    logic [CNT_W-1:0] cnt_s, per_s;
    logic [CNT_W-1:0] len_sel, hi_sel;
    launch_t          req;
    logic             ext_q;
    logic             busy, first, last, in_hi;
    logic             follow;

    assign mode   = mode_e'(mode_i);
    assign trig   = trig_e'(trig_i);
    assign follow = (mode == MD_FOLLOW);

    bseq_cfg_guard #(
        .CNT_W(CNT_W), .MIN_CNT(MIN_CNT), .MIN_PER(MIN_PER), .MAX_LEN(MAX_LEN)
    ) u_cfg (
        .clk(clk), .rst(rst),
        .cnt_i(burst_cnt_i), .per_i(burst_per_i),
        .cnt_o(cnt_s), .per_o(per_s), .err_o(cfg_err_o)
    );

    bseq_trig u_trig (
        .clk(clk), .rst(rst), .trig(trig),
        .ext_i(ext_i), .sw_i(sw_trig_i),
        .req_o(req), .ext_q_o(ext_q)
    );

    always_comb begin
        unique case (mode)
            MD_PULSE: begin
                len_sel = ONE;
                hi_sel  = ONE;
            end
            MD_BURST: begin
                len_sel = per_s;
                hi_sel  = cnt_s;
            end
            MD_PATTERN: begin
                len_sel = per_s;
                hi_sel  = per_s;
            end
            default: begin
                len_sel = ONE;
                hi_sel  = ONE;
            end
        endcase
    end

    bseq_frame #(.CNT_W(CNT_W)) u_frm (
        .clk(clk), .rst(rst), .hold(follow), .req(req),
        .len_i(len_sel), .hi_i(hi_sel),
        .busy_o(busy), .first_o(first), .last_o(last), .in_hi_o(in_hi)
    );

    // follow mode: ext_q is ext_i one clock late, matching frame latency
    assign pulse_en_o = follow ? ext_q : in_hi;
    assign trig_out_o = !follow && first;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_i,
    input logic [CNT_W-1:0] burst_cnt_i,
    input logic [CNT_W-1:0] burst_per_i,
    input logic             ext_i,
    input logic             pulse_en_o,
    input logic             trig_out_o,
    input logic             cfg_err_o,
    input logic             busy,
    input logic             last
);
    // R1
    strobe_has_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_out_o && mode_i != MD_FOLLOW) |-> pulse_en_o);

    // R8
    follow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == MD_FOLLOW && !$past(rst)) |-> !trig_out_o);

    // R8
    follow_track_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == MD_FOLLOW && mode_i == MD_FOLLOW && !$past(rst))
            |-> (pulse_en_o == $past(ext_i)));

    // R9
    short_period_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_per_i < CNT_W'(8)) |=> cfg_err_o);

    // R9
    count_over_period_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_cnt_i > burst_per_i) |=> cfg_err_o);

    // R5
    no_midframe_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last && mode_i != MD_FOLLOW) |=> !trig_out_o);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!pulse_en_o && !trig_out_o && !cfg_err_o));
endmodule

bind burst_seq burst_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .burst_cnt_i(burst_cnt_i), .burst_per_i(burst_per_i), .ext_i(ext_i),
    .pulse_en_o(pulse_en_o), .trig_out_o(trig_out_o), .cfg_err_o(cfg_err_o),
    .busy(busy), .last(last)
);

// File: tb/sim_burst_seq.sv
module sim_burst_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = 2'd3;
    logic [1:0]  trig_i = 2'd0;
    logic [20:0] burst_cnt_i = 21'd2;
    logic [20:0] burst_per_i = 21'd8;
    logic        ext_i = 1'b0;
    logic        sw_trig_i = 1'b0;
    logic        pulse_en_o, trig_out_o, cfg_err_o;

    int checks = 0;
    int errors = 0;
    int pc = 0;
    int tc = 0;

    always #10 clk = ~clk;

    burst_seq u0 (
        .clk(clk), .rst(rst), .mode_i(mode_i), .trig_i(trig_i),
        .burst_cnt_i(burst_cnt_i), .burst_per_i(burst_per_i),
        .ext_i(ext_i), .sw_trig_i(sw_trig_i),
        .pulse_en_o(pulse_en_o), .trig_out_o(trig_out_o), .cfg_err_o(cfg_err_o)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [20:0] c;
        logic [20:0] p;
        logic [15:0] n;
        logic [15:0] pe;
        logic [15:0] te;
    } vec_t;

    // internal trigger, counted over whole frames
    localparam vec_t VECS [8] = '{
        '{2'd1, 21'd3,  21'd8,  16'd32, 16'd12, 16'd4},
        '{2'd1, 21'd2,  21'd8,  16'd16, 16'd4,  16'd2},
        '{2'd1, 21'd8,  21'd8,  16'd16, 16'd16, 16'd2},
        '{2'd1, 21'd5,  21'd10, 16'd30, 16'd15, 16'd3},
        '{2'd1, 21'd2,  21'd9,  16'd27, 16'd6,  16'd3},
        '{2'd2, 21'd2,  21'd8,  16'd24, 16'd24, 16'd3},
        '{2'd2, 21'd4,  21'd12, 16'd24, 16'd24, 16'd2},
        '{2'd0, 21'd2,  21'd8,  16'd10, 16'd10, 16'd10}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        pc += int'(pulse_en_o);
        tc += int'(trig_out_o);
    endtask

    task automatic idle_cfg(input logic [20:0] c, input logic [20:0] p);
        mode_i = 2'd3; ext_i = 1'b0; sw_trig_i = 1'b0;
        burst_cnt_i = c; burst_per_i = p;
        repeat (3) @(negedge clk);
        pc = 0; tc = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        mode_i = 2'd1; trig_i = 2'd3;
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 pulse_en after reset", int'(pulse_en_o), 0);
        check("R10 trig_out after reset", int'(trig_out_o), 0);
        check("R10 cfg_err after reset", int'(cfg_err_o), 0);

        // R1 R2 R3 R4 table walk
        foreach (VECS[i]) begin
            idle_cfg(VECS[i].c, VECS[i].p);
            mode_i = VECS[i].md; trig_i = 2'd0;
            for (int k = 0; k < int'(VECS[i].n); k++) tick();
            check($sformatf("R1/R2/R3 R4 vec%0d enables", i), pc, int'(VECS[i].pe));
            check($sformatf("R4 vec%0d strobes", i), tc, int'(VECS[i].te));
        end

        // R7 software: second strobe mid-frame ignored
        idle_cfg(21'd3, 21'd8);
        mode_i = 2'd1; trig_i = 2'd3;
        sw_trig_i = 1'b1; tick(); sw_trig_i = 1'b0;
        tick(); sw_trig_i = 1'b1; tick(); sw_trig_i = 1'b0;
        for (int k = 0; k < 17; k++) tick();
        check("R7 soft enables", pc, 3);
        check("R7 soft strobes", tc, 1);

        // R5 edge: rise mid-frame dropped, later rise accepted
        idle_cfg(21'd4, 21'd16);
        mode_i = 2'd1; trig_i = 2'd1;
        ext_i = 1'b1; tick(); ext_i = 1'b0; tick(); tick();
        ext_i = 1'b1; tick(); ext_i = 1'b0;
        for (int k = 0; k < 20; k++) tick();
        check("R5 edge enables", pc, 4);
        check("R5 edge strobes", tc, 1);
        ext_i = 1'b1; tick(); ext_i = 1'b0;
        for (int k = 0; k < 17; k++) tick();
        check("R5 edge relaunch enables", pc, 8);

        // R6 level: second frame completes after level drops
        idle_cfg(21'd2, 21'd8);
        mode_i = 2'd1; trig_i = 2'd2;
        ext_i = 1'b1;
        for (int k = 0; k < 10; k++) tick();
        ext_i = 1'b0;
        for (int k = 0; k < 20; k++) tick();
        check("R6 level enables", pc, 4);
        check("R6 level strobes", tc, 2);

        // R3 single pulse on edges, R6 level in pulse mode
        idle_cfg(21'd2, 21'd8);
        mode_i = 2'd0; trig_i = 2'd1;
        for (int r = 0; r < 3; r++) begin
            ext_i = 1'b1; tick(); tick(); ext_i = 1'b0; tick(); tick();
        end
        check("R3 edge pulses", pc, 3);
        check("R3 edge strobes", tc, 3);
        idle_cfg(21'd2, 21'd8);
        mode_i = 2'd0; trig_i = 2'd2;
        ext_i = 1'b1;
        for (int k = 0; k < 5; k++) tick();
        ext_i = 1'b0;
        for (int k = 0; k < 3; k++) tick();
        check("R6 pulse-level count", pc, 5);

        // R8 follow mode
        idle_cfg(21'd2, 21'd8);
        trig_i = 2'd0;
        for (int k = 0; k < 8; k++) begin
            ext_i = ((8'b1011_0110 >> k) & 8'd1) != 0;
            tick();
            check("R8 follow level", int'(pulse_en_o), int'(ext_i));
            check("R8 follow strobe", int'(trig_out_o), 0);
        end

        // R9 rejected settings keep 3/8
        idle_cfg(21'd3, 21'd8);
        burst_per_i = 21'd7; tick();
        check("R9 period<8 flagged", int'(cfg_err_o), 1);
        mode_i = 2'd1; trig_i = 2'd0; pc = 0; tc = 0;
        for (int k = 0; k < 32; k++) tick();
        check("R9 previous setting kept", pc, 12);
        check("R9 previous period kept", tc, 4);
        idle_cfg(21'd3, 21'd8);
        burst_cnt_i = 21'd1; tick();
        check("R9 count<2 flagged", int'(cfg_err_o), 1);
        burst_cnt_i = 21'd9; burst_per_i = 21'd8; tick();
        check("R9 count>period flagged", int'(cfg_err_o), 1);
        burst_cnt_i = 21'd1048577; burst_per_i = 21'd1048577; tick();
        check("R9 over max flagged", int'(cfg_err_o), 1);
        burst_cnt_i = 21'd2; burst_per_i = 21'd8; tick();
        check("R9 minimum accepted", int'(cfg_err_o), 0);
        burst_cnt_i = 21'd1048576; burst_per_i = 21'd1048576; tick();
        check("R9 maximum accepted", int'(cfg_err_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule